// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Converter

This block turns a signed or unsigned fixed-point number into an IEEE binary floating-point value in half, single or double format. The fixed-point operand is 16 or 32 bits wide and sits in the low bits of a wider source word. The caller gives the number of fraction bits as a 5-bit code that is subtracted from the operand width. Each cycle the block samples its inputs and registers the converted result together with an inexact flag, an overflow flag, an undefined-format flag and an invalid-count flag. The result appears one clock later.

It is meant to sit in the datapath of a floating-point unit, where it handles the conversion from fixed point. The results are right-aligned in a 64-bit word and the unused upper bits are zero. Rounding is always to the nearest value, with ties going to the even value.

Top module: `fx2fp_conv`

## Requirements
- R1: With `is_wide`=0 the operand is `src_word[15:0]`. With `is_wide`=1 it is `src_word[31:0]`. No other bit of `src_word` changes any output.
- R2: With `is_unsigned`=1 the operand is unsigned. With `is_unsigned`=0 it is two's-complement signed. The pairs {`is_unsigned`,`is_wide`} 00, 01, 10 and 11 select signed 16, signed 32, unsigned 16 and unsigned 32.
- R3: The fraction count is 16 or 32 (the operand width) minus `frac_code`. A negative count sets `fl_invalid`, and then the result and all other flags are 0.
- R4: `fmt` selects the output format: 01 gives half in bits [15:0], 10 gives single in bits [31:0] and 11 gives double in bits [63:0]. All result bits above the format are zero. `fmt`=00 sets `fl_undef`, and then the result and all other flags are 0.
- R5: The result is the operand times 2^-count. It is exact whenever the format can represent that value, and a double result is always exact.
- R6: Rounding is to nearest with ties to even. `fl_inexact` is 1 exactly when rounding discards nonzero bits or when the result overflows.
- R7: A zero operand gives +0.0 with no flags set.
- R8: The most negative signed operand (-2^15 or -2^31) converts exactly.
- R9: In half format, a rounded magnitude above 65504 gives an infinity with the operand's sign, and sets both `fl_overflow` and `fl_inexact`.
- R10: Half-format magnitudes below 2^-14 give correctly rounded subnormal results. They may round to a signed zero, or round up to the smallest normal value.
- R11: Outputs are registered with one cycle of latency. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | SRC_W | Source word; the operand is taken from its low bits |
| fmt | input | 2 | Output format code |
| is_unsigned | input | 1 | 1 = unsigned operand |
| is_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| frac_code | input | 5 | Fraction count, encoded as operand width minus count |
| fp_result | output | 64 | Floating-point result, right-aligned |
| fl_inexact | output | 1 | Result was rounded or overflowed |
| fl_overflow | output | 1 | Half-format result overflowed to infinity |
| fl_undef | output | 1 | Format code 00 was given |
| fl_invalid | output | 1 | Fraction count was negative |

## Verification
The bench builds the converter with the default 64-bit source word. Bits 32 to 63 of the source word can therefore be driven with junk to show that they are ignored, and so can bits 16 to 31 for 16-bit operands. The stimulus covers all three formats with operand widths at both limits and fraction counts from 0 to 32. This reaches exact ties in both directions, the half overflow boundary at 65504/65520, subnormals that round to zero or carry into the smallest normal, and the most negative signed operands.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;

  localparam int OP_W  = 32;
  localparam int RES_W = 64;

  typedef enum logic [1:0] {
    FMT_NONE   = 2'b00,
    FMT_HALF   = 2'b01,
    FMT_SINGLE = 2'b10,
    FMT_DOUBLE = 2'b11
  } fmt_e;

  // Normalised operand handed from the front end to the rounders.
  typedef struct packed {
    logic              sign;
    logic              zero;
    logic [OP_W-1:0]   norm;   // leading one at bit OP_W-1
    logic signed [7:0] expo;   // unbiased exponent of the leading one
  } fx_norm_t;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      1:       return 5;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(input int idx);
    case (idx)
      1:       return 10;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fx2fp_front.sv
module fx2fp_front
  import fx2fp_pkg::*;
(
  input  logic [OP_W-1:0] op_bits,
  input  logic            is_unsigned,
  input  logic            is_wide,
  input  logic [4:0]      frac_code,
  output fx_norm_t        nrm,
  output logic            invalid
);

  logic [OP_W-1:0]   op;
  logic [OP_W-1:0]   mag;
  logic [4:0]        lead;
  logic signed [7:0] fbits;
  logic              neg;

  always_comb begin
    op    = is_wide ? op_bits
                    : {{(OP_W/2){~is_unsigned & op_bits[OP_W/2-1]}}, op_bits[OP_W/2-1:0]};
    neg   = ~is_unsigned & op[OP_W-1];
    mag   = neg ? (~op + 1'b1) : op;
    lead  = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (mag[i]) lead = 5'(i);
    end
    fbits    = (is_wide ? 8'sd32 : 8'sd16) - $signed({3'b000, frac_code});
    invalid  = fbits < 0;
    nrm.sign = neg;
    nrm.zero = (mag == '0);
    nrm.norm = mag << (5'd31 - lead);
    nrm.expo = $signed({3'b000, lead}) - fbits;
  end

endmodule

// File: rtl/fx2fp_round.sv
module fx2fp_round
  import fx2fp_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  fx_norm_t         nrm,
  output logic [RES_W-1:0] res,
  output logic             inexact,
  output logic             overflow
);

  localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
  localparam int EMIN  = 1 - BIAS;
  localparam int PK_W  = EXP_W + MAN_W + 1;
  localparam int G_POS = 62 - MAN_W;
  localparam logic [PK_W-1:0] INF_PK = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic [63:0]     x, shf;
  logic [5:0]      dsh;
  logic [MAN_W:0]  kept;
  logic [PK_W-1:0] pack;
  logic            lost, guard, sticky, rnd, ovf;
  int              e_i, dsh_i, ebe_i;

  always_comb begin
    e_i   = int'(nrm.expo);
    dsh_i = (e_i < EMIN) ? (EMIN - e_i) : 0;
    if (dsh_i > 63) dsh_i = 63;
    dsh    = 6'(dsh_i);
    x      = {nrm.norm, 32'b0};
    shf    = x >> dsh;
    lost   = |(x & ~({64{1'b1}} << dsh));
    kept   = shf[63 -: MAN_W+1];
    guard  = shf[G_POS];
    sticky = lost | (|shf[G_POS-1:0]);
    rnd    = guard & (sticky | kept[0]);
    ebe_i  = ((e_i < EMIN) ? EMIN : e_i) + BIAS;
    pack   = (PK_W'(ebe_i - 1) << MAN_W) + PK_W'(kept) + PK_W'(rnd);
    ovf    = pack >= INF_PK;
    if (nrm.zero) begin
      res      = '0;
      inexact  = 1'b0;
      overflow = 1'b0;
    end else begin
      res      = RES_W'({nrm.sign, (ovf ? INF_PK[PK_W-2:0] : pack[PK_W-2:0])});
      inexact  = ovf | guard | sticky;
      overflow = ovf;
    end
  end

endmodule

// File: rtl/fx2fp_conv.sv
module fx2fp_conv
  import fx2fp_pkg::*;
#(
  parameter int SRC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_word,
  input  logic [1:0]       fmt,
  input  logic             is_unsigned,
  input  logic             is_wide,
  input  logic [4:0]       frac_code,
  output logic [RES_W-1:0] fp_result,
  output logic             fl_inexact,
  output logic             fl_overflow,
  output logic             fl_undef,
  output logic             fl_invalid
);

  localparam int NFMT = 3;

  fx_norm_t         nrm;
  logic             bad_count;
  logic [RES_W-1:0] res_a [NFMT];
  logic             inx_a [NFMT];
  logic             ovf_a [NFMT];
  logic [RES_W-1:0] res_n;
  logic             inx_n, ovf_n, und_n;
  logic             src_unused_hi;

  assign src_unused_hi = ^src_word[SRC_W-1:OP_W];

  fx2fp_front u_front (
    .op_bits    (src_word[OP_W-1:0]),
    .is_unsigned(is_unsigned),
    .is_wide    (is_wide),
    .frac_code  (frac_code),
    .nrm        (nrm),
    .invalid    (bad_count)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    fx2fp_round #(
      .EXP_W(fmt_exp_w(g + 1)),
      .MAN_W(fmt_man_w(g + 1))
    ) u_rnd (
      .nrm     (nrm),
      .res     (res_a[g]),
      .inexact (inx_a[g]),
      .overflow(ovf_a[g])
    );
  end

  always_comb begin
    res_n = '0;
    inx_n = 1'b0;
    ovf_n = 1'b0;
    und_n = 1'b0;
    case (fmt_e'(fmt))
      FMT_HALF:   begin res_n = res_a[0]; inx_n = inx_a[0]; ovf_n = ovf_a[0]; end
      FMT_SINGLE: begin res_n = res_a[1]; inx_n = inx_a[1]; ovf_n = ovf_a[1]; end
      FMT_DOUBLE: begin res_n = res_a[2]; inx_n = inx_a[2]; ovf_n = ovf_a[2]; end
      default:    und_n = 1'b1;
    endcase
    if (und_n || bad_count) begin
      res_n = '0;
      inx_n = 1'b0;
      ovf_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_result   <= '0;
      fl_inexact  <= 1'b0;
      fl_overflow <= 1'b0;
      fl_undef    <= 1'b0;
      fl_invalid  <= 1'b0;
    end else begin
      fp_result   <= res_n;
      fl_inexact  <= inx_n;
      fl_overflow <= ovf_n;
      fl_undef    <= und_n;
      fl_invalid  <= bad_count & ~und_n;
    end
  end

endmodule

// File: rtl/fx2fp_checks.sv
module fx2fp_checks #(
  parameter int SRC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [SRC_W-1:0] src_word,
  input logic [1:0]       fmt,
  input logic             is_unsigned,
  input logic             is_wide,
  input logic [4:0]       frac_code,
  input logic [63:0]      fp_result,
  input logic             fl_inexact,
  input logic             fl_overflow,
  input logic             fl_undef,
  input logic             fl_invalid
);

  logic chk_unused_hi;
  assign chk_unused_hi = ^src_word[SRC_W-1:16];

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (fp_result == '0 && !fl_inexact && !fl_overflow && !fl_undef && !fl_invalid));

  a_r4_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    fl_undef |-> (fp_result == '0 && !fl_inexact && !fl_overflow && !fl_invalid));

  a_r4_undef_code: assert property (@(posedge clk) disable iff (rst)
    (fmt == 2'b00) |=> fl_undef);

  a_r4_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (fmt == 2'b01) |=> (fp_result[63:16] == '0));

  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    fl_invalid |-> (fp_result == '0 && !fl_inexact && !fl_overflow));

  a_r9_overflow_inf: assert property (@(posedge clk) disable iff (rst)
    fl_overflow |-> (fl_inexact && fp_result[14:0] == 15'h7C00 && fp_result[63:16] == '0));

  a_r7_zero_plus: assert property (@(posedge clk) disable iff (rst)
    (!is_wide && src_word[15:0] == 16'h0 && fmt != 2'b00 && frac_code <= 5'd16)
      |=> (fp_result == '0 && !fl_inexact));

  a_r2_unsigned_positive: assert property (@(posedge clk) disable iff (rst)
    (is_unsigned && fmt == 2'b10) |=> !fp_result[31]);

endmodule

bind fx2fp_conv fx2fp_checks #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/fx2fp_conv_bench.sv
module fx2fp_conv_bench;

  localparam int SRC_W = 64;
  localparam int N     = 27;

  // {req, fmt, unsigned, wide, code, src, expected, {inexact,overflow,undef,invalid}}
  localparam logic [144:0] VEC [N] = '{
    {4'd4,  2'b01, 1'b1, 1'b0, 5'd16, 64'h1,                 64'h3C00,             4'b0000}, // R4 half 1.0
    {4'd1,  2'b10, 1'b0, 1'b0, 5'd16, 64'hDEADBEEF_1234FFFF, 64'hBF800000,         4'b0000}, // R1 junk above
    {4'd8,  2'b11, 1'b0, 1'b1, 5'd0,  64'h80000000,          64'hBFE0000000000000, 4'b0000}, // R8 -2^31
    {4'd6,  2'b10, 1'b1, 1'b1, 5'd0,  64'hFFFFFFFF,          64'h3F800000,         4'b1000}, // R6 carry
    {4'd6,  2'b10, 1'b1, 1'b1, 5'd31, 64'h01000001,          64'h4B000000,         4'b1000}, // R6 tie down
    {4'd6,  2'b10, 1'b1, 1'b1, 5'd31, 64'h01000003,          64'h4B000002,         4'b1000}, // R6 tie up
    {4'd9,  2'b01, 1'b1, 1'b0, 5'd16, 64'hFFFF,              64'h7C00,             4'b1100}, // R9
    {4'd9,  2'b01, 1'b1, 1'b0, 5'd16, 64'hFFEF,              64'h7BFF,             4'b1000}, // R9 max
    {4'd9,  2'b01, 1'b1, 1'b0, 5'd16, 64'hFFF0,              64'h7C00,             4'b1100}, // R9 tie
    {4'd9,  2'b01, 1'b0, 1'b1, 5'd31, 64'hFFFCF2C0,          64'hFC00,             4'b1100}, // R9 neg
    {4'd10, 2'b01, 1'b1, 1'b0, 5'd0,  64'h1,                 64'h0100,             4'b0000}, // R10
    {4'd10, 2'b01, 1'b1, 1'b1, 5'd0,  64'h1,                 64'h0000,             4'b1000}, // R10
    {4'd10, 2'b01, 1'b0, 1'b1, 5'd0,  64'hFFFFFFFF,          64'h8000,             4'b1000}, // R10
    {4'd10, 2'b01, 1'b1, 1'b1, 5'd0,  64'h180,               64'h0002,             4'b1000}, // R10 tie
    {4'd10, 2'b01, 1'b1, 1'b1, 5'd0,  64'h3FFFF,             64'h0400,             4'b1000}, // R10 carry
    {4'd7,  2'b11, 1'b0, 1'b1, 5'd0,  64'hFFFFFFFF_00000000, 64'h0,                4'b0000}, // R7
    {4'd3,  2'b01, 1'b0, 1'b0, 5'd17, 64'h5,                 64'h0,                4'b0001}, // R3
    {4'd4,  2'b00, 1'b0, 1'b0, 5'd16, 64'h5,                 64'h0,                4'b0010}, // R4 undef
    {4'd5,  2'b11, 1'b1, 1'b1, 5'd16, 64'h00030000,          64'h4008000000000000, 4'b0000}, // R5
    {4'd8,  2'b10, 1'b0, 1'b0, 5'd0,  64'h8000,              64'hBF000000,         4'b0000}, // R8
    {4'd8,  2'b01, 1'b0, 1'b0, 5'd16, 64'h8000,              64'hF800,             4'b0000}, // R8
    {4'd6,  2'b01, 1'b1, 1'b0, 5'd16, 64'h0801,              64'h6800,             4'b1000}, // R6
    {4'd6,  2'b01, 1'b1, 1'b0, 5'd16, 64'h0803,              64'h6802,             4'b1000}, // R6
    {4'd2,  2'b10, 1'b1, 1'b0, 5'd16, 64'hFFFF,              64'h477FFF00,         4'b0000}, // R2
    {4'd3,  2'b01, 1'b0, 1'b0, 5'd16, 64'h3,                 64'h4200,             4'b0000}, // R3 count 0
    {4'd5,  2'b11, 1'b0, 1'b1, 5'd8,  64'hFFFFFF00,          64'hBEF0000000000000, 4'b0000}, // R5
    {4'd1,  2'b01, 1'b1, 1'b0, 5'd16, 64'hFFFFFFFF_FFFF0002, 64'h4000,             4'b0000}  // R1
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SRC_W-1:0] src_word = '0;
  logic [1:0]       fmt = 2'b01;
  logic             is_unsigned = 1'b0;
  logic             is_wide = 1'b0;
  logic [4:0]       frac_code = 5'd16;
  logic [63:0]      fp_result;
  logic             fl_inexact, fl_overflow, fl_undef, fl_invalid;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  fx2fp_conv #(.SRC_W(SRC_W)) u_fx2fp_conv (
    .clk(clk), .rst(rst), .src_word(src_word), .fmt(fmt),
    .is_unsigned(is_unsigned), .is_wide(is_wide), .frac_code(frac_code),
    .fp_result(fp_result), .fl_inexact(fl_inexact), .fl_overflow(fl_overflow),
    .fl_undef(fl_undef), .fl_invalid(fl_invalid)
  );

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [67:0] outs();
    return {fp_result, fl_inexact, fl_overflow, fl_undef, fl_invalid};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 reset state", outs(), 68'h0);
    rst = 1'b0;

    for (int k = 0; k < N; k++) begin
      logic [144:0] ent;
      ent = VEC[k];
      @(negedge clk);
      fmt         = ent[140:139];
      is_unsigned = ent[138];
      is_wide     = ent[137];
      frac_code   = ent[136:132];
      src_word    = ent[131:68];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", ent[144:141], k), outs(), ent[67:0]);
    end

    // R11: one-cycle latency, output holds old value before the edge
    @(negedge clk);
    fmt = 2'b01; is_unsigned = 1'b1; is_wide = 1'b0; frac_code = 5'd16; src_word = 64'h1;
    @(negedge clk);
    fmt = 2'b01; src_word = 64'h2;
    #1;
    check("R11 latency old", outs(), {64'h3C00, 4'b0000});
    @(negedge clk);
    check("R11 latency new", outs(), {64'h4000, 4'b0000});

    // R11: synchronous reset clears a nonzero result
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears", outs(), 68'h0);
    rst = 1'b0;

    // R1: upper operand bits ignored for a 32-bit operand too
    fmt = 2'b11; is_unsigned = 1'b1; is_wide = 1'b1; frac_code = 5'd16;
    src_word = 64'hA5A5A5A5_00030000;
    @(negedge clk);
    check("R1 wide junk", outs(), {64'h4008000000000000, 4'b0000});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule